// File: doc/BRIEF.md
# Byte-Bus to 12-Bit DAC Loader

This block takes writes from an 8-bit processor-style bus and turns them into clean load cycles for a 12-bit parallel DAC. The DAC has an input latch with active-low chip-select and write strobes. That latch is transparent whenever both strobes are low. The block therefore drives the DAC data lines from its own register and asserts the strobes only after the data has settled. The data stays frozen while the strobes are low and for a while after they rise.

Two load methods are offered, selected by a configuration input.

- **Byte mode.** A write to one byte address parks the low eight code bits in a shadow register. A write to a second address supplies the top four bits and starts the DAC cycle. The DAC therefore never sees half of an update.
- **Address-field mode.** A single write carries the whole code in the low twelve address bits. The upper four address bits select which 4K-location window the loader answers to.

An optional two's-complement setting flips the code's top bit, so that signed samples reach the DAC as offset binary. Writes that arrive while a strobe cycle is in progress are held off with a ready signal and are never lost.

Top module: `dacbus_loader`

## Requirements
- R1: While `rst` is high and until the first load, `dac_cs_n` and `dac_wr_n` are 1 and `bus_ready` is 1. `dac_data` rests at 0x000 when `cfg_twos` is 0 and at 0x800 when `cfg_twos` is 1.
- R2: In byte mode (`cfg_addr_mode`=0), a write to `HI_ADDR` (default 0x4001) loads the DAC with {`bus_wdata[3:0]`, low byte}. Here the low byte is the last value written to `LO_ADDR` (default 0x4000), and `bus_wdata[7:4]` is ignored.
- R3: In byte mode, a write to `LO_ADDR` alone produces no strobe and leaves `dac_data` unchanged.
- R4: In address-field mode (`cfg_addr_mode`=1), a write whose `bus_addr[15:12]` equals `cfg_block` loads `bus_addr[11:0]`. A write with any other block number produces no strobe and no stall.
- R5: With `cfg_twos`=1, bit 11 of the loaded code is inverted before it reaches `dac_data`. For example, 0x7FF becomes 0xFFF, 0x800 becomes 0x000, and 0x000 becomes 0x800.
- R6: Each load produces exactly one strobe pulse. During the pulse, `dac_cs_n` and `dac_wr_n` are both low for exactly `PULSE_CYC` (default 10) clock cycles.
- R7: `dac_data` takes its new value at least `SETUP_CYC` (default 1) cycles before the strobes fall. It does not change while they are low, and it keeps its value for at least `HOLD_CYC` (default 1) cycles after they rise.
- R8: `bus_ready` is 0 from the cycle after a load is accepted until the strobe sequence ends. A write held during that time completes afterwards with its own strobe pulse.
- R9: In byte mode, writes to addresses other than `LO_ADDR` and `HI_ADDR` produce no strobe and leave the held low byte unchanged.
- R10: The held low byte survives a load. A second `HI_ADDR` write with no new `LO_ADDR` write reuses it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_addr_mode | input | 1 | 0 = two-write byte load, 1 = single-write address-field load |
| cfg_twos | input | 1 | 1 = invert code MSB (two's complement to offset binary) |
| cfg_block | input | 4 | Window number matched against the upper address bits in address-field mode |
| bus_we | input | 1 | Bus write request, held until accepted |
| bus_addr | input | 16 | Bus write address |
| bus_wdata | input | 8 | Bus write data byte |
| bus_ready | output | 1 | High when a write can be accepted this cycle |
| dac_data | output | 12 | Code presented to the DAC data lines |
| dac_cs_n | output | 1 | Active-low DAC chip-select |
| dac_wr_n | output | 1 | Active-low DAC write strobe |

## Verification
The bench measures every strobe pulse at the pins. It checks the pulse width, whether the data was already in place the cycle before the fall, and whether the data stayed put through the pulse and the hold cycle.

- A design that drove the data in the same cycle as the strobe fall would expose a stale code to the transparent latch.
- A design that strobed on the low-byte write would show a half-updated code.
- A design that dropped writes arriving during a busy sequence would miss the second of two back-to-back loads.

Further tests target the shadow byte: it must not be touched by stray addresses, and it must be reused by a lone high-nibble write. Address-field writes to a foreign window must be ignored. The two's-complement mapping is checked at both extremes and at mid-scale, together with the mid-scale rest value after reset.

// File: rtl/dbl_pkg.sv
package dbl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_PULSE = 2'd2,
    ST_HOLD  = 2'd3
  } seq_state_e;

endpackage

// File: rtl/dbl_decode.sv
module dbl_decode #(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8,
  parameter int CODE_W = 12,
  parameter logic [ADDR_W-1:0] LO_ADDR = 16'h4000,
  parameter logic [ADDR_W-1:0] HI_ADDR = 16'h4001
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       fire,
  input  logic                       addr_mode,
  input  logic [ADDR_W-CODE_W-1:0]   block_id,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [BYTE_W-1:0]          wdata,
  output logic                       load_req,
  output logic [CODE_W-1:0]          load_code
);
  localparam int HI_W  = CODE_W - BYTE_W;
  localparam int BLK_W = ADDR_W - CODE_W;

  logic [BYTE_W-1:0] shadow_q;
  logic              hit_lo, hit_hi, hit_blk;
  logic [BLK_W-1:0]  addr_blk;

  always_comb begin
    addr_blk = addr[ADDR_W-1 -: BLK_W];
    hit_lo   = fire && !addr_mode && (addr == LO_ADDR);
    hit_hi   = fire && !addr_mode && (addr == HI_ADDR);
    hit_blk  = fire &&  addr_mode && (addr_blk == block_id);
    load_req = hit_hi || hit_blk;
    if (addr_mode) load_code = addr[CODE_W-1:0];
    else           load_code = {wdata[HI_W-1:0], shadow_q};
  end

  always_ff @(posedge clk) begin
    if (rst)         shadow_q <= '0;
    else if (hit_lo) shadow_q <= wdata;
  end

  // R3: a low-byte write never starts a DAC load by itself
  a_r3_lo_no_load: assert property (@(posedge clk) disable iff (rst)
    (fire && !addr_mode && addr == LO_ADDR) |-> !load_req);

  // R10: shadow only moves on a low-byte write
  a_r10_shadow_kept: assert property (@(posedge clk) disable iff (rst)
    !$past(hit_lo) |-> $stable(shadow_q));
endmodule

// File: rtl/dbl_code_map.sv
module dbl_code_map #(
  parameter int CODE_W = 12
) (
  input  logic              twos,
  input  logic [CODE_W-1:0] code_in,
  output logic [CODE_W-1:0] code_out
);
  for (genvar i = 0; i < CODE_W; i++) begin : g_bit
    if (i == CODE_W - 1) begin : g_msb
      assign code_out[i] = code_in[i] ^ twos;
    end else begin : g_pass
      assign code_out[i] = code_in[i];
    end
  end
endmodule

// File: rtl/dbl_strobe_seq.sv
module dbl_strobe_seq
  import dbl_pkg::*;
#(
  parameter int CODE_W    = 12,
  parameter int SETUP_CYC = 1,
  parameter int PULSE_CYC = 10,
  parameter int HOLD_CYC  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              twos,
  input  logic              load_req,
  input  logic [CODE_W-1:0] load_code,
  output logic [CODE_W-1:0] dac_data,
  output logic              dac_cs_n,
  output logic              dac_wr_n,
  output logic              busy
);
  localparam int MAX_CYC = (PULSE_CYC > SETUP_CYC) ?
                           ((PULSE_CYC > HOLD_CYC) ? PULSE_CYC : HOLD_CYC) :
                           ((SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC);
  localparam int CNT_W = $clog2(MAX_CYC + 1);
  localparam int RUN_W = $clog2(PULSE_CYC + 2);
  localparam logic [CNT_W-1:0] SETUP_LD = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] PULSE_LD = CNT_W'(PULSE_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_LD  = CNT_W'(HOLD_CYC - 1);

  seq_state_e       st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CODE_W-1:0] rest_code;
  logic             cnt_zero;

  assign rest_code = {twos, {(CODE_W-1){1'b0}}};
  assign cnt_zero  = (cnt_q == '0);
  assign busy      = (st_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      cnt_q    <= '0;
      dac_data <= rest_code;
      dac_cs_n <= 1'b1;
      dac_wr_n <= 1'b1;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (load_req) begin
            dac_data <= load_code;
            cnt_q    <= SETUP_LD;
            st_q     <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          if (cnt_zero) begin
            dac_cs_n <= 1'b0;
            dac_wr_n <= 1'b0;
            cnt_q    <= PULSE_LD;
            st_q     <= ST_PULSE;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_PULSE: begin
          if (cnt_zero) begin
            dac_cs_n <= 1'b1;
            dac_wr_n <= 1'b1;
            cnt_q    <= HOLD_LD;
            st_q     <= ST_HOLD;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: begin
          if (cnt_zero) st_q  <= ST_IDLE;
          else          cnt_q <= cnt_q - 1'b1;
        end
      endcase
    end
  end

  // Independent pulse-length counter for the checker
  logic [RUN_W-1:0] low_run_q;
  always_ff @(posedge clk) begin
    if (rst)            low_run_q <= '0;
    else if (!dac_wr_n) low_run_q <= low_run_q + 1'b1;
    else                low_run_q <= '0;
  end

  // R6: strobe low for exactly PULSE_CYC cycles
  a_r6_pulse_width: assert property (@(posedge clk) disable iff (rst)
    $rose(dac_wr_n) |-> (low_run_q == RUN_W'(PULSE_CYC)));

  // R6: chip-select and write strobe move together
  a_r6_cs_with_wr: assert property (@(posedge clk) disable iff (rst)
    (dac_cs_n == dac_wr_n));

  // R7: data unchanged while strobes are low (including the falling cycle)
  a_r7_data_frozen: assert property (@(posedge clk) disable iff (rst)
    !dac_wr_n |-> $stable(dac_data));

  // R7: data still held in the cycle the strobe rises
  a_r7_data_hold: assert property (@(posedge clk) disable iff (rst)
    $rose(dac_wr_n) |-> $stable(dac_data));

  // R8: sequencer reports busy whenever the strobe is active
  a_r8_busy_in_pulse: assert property (@(posedge clk) disable iff (rst)
    !dac_wr_n |-> busy);
endmodule

// File: rtl/dacbus_loader.sv
module dacbus_loader #(
  parameter int ADDR_W    = 16,
  parameter int BYTE_W    = 8,
  parameter int CODE_W    = 12,
  parameter int SETUP_CYC = 1,
  parameter int PULSE_CYC = 10,
  parameter int HOLD_CYC  = 1,
  parameter logic [ADDR_W-1:0] LO_ADDR = 16'h4000,
  parameter logic [ADDR_W-1:0] HI_ADDR = 16'h4001
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfg_addr_mode,
  input  logic                     cfg_twos,
  input  logic [ADDR_W-CODE_W-1:0] cfg_block,
  input  logic                     bus_we,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [BYTE_W-1:0]        bus_wdata,
  output logic                     bus_ready,
  output logic [CODE_W-1:0]        dac_data,
  output logic                     dac_cs_n,
  output logic                     dac_wr_n
);
  localparam int BLK_W = ADDR_W - CODE_W;

  logic              fire, load_req, busy;
  logic [CODE_W-1:0] raw_code, mapped_code;

  assign bus_ready = !busy;
  assign fire      = bus_we && bus_ready;

  dbl_decode #(
    .ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .CODE_W(CODE_W),
    .LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR)
  ) u_decode (
    .clk(clk), .rst(rst), .fire(fire), .addr_mode(cfg_addr_mode),
    .block_id(cfg_block), .addr(bus_addr), .wdata(bus_wdata),
    .load_req(load_req), .load_code(raw_code)
  );

  dbl_code_map #(.CODE_W(CODE_W)) u_map (
    .twos(cfg_twos), .code_in(raw_code), .code_out(mapped_code)
  );

  dbl_strobe_seq #(
    .CODE_W(CODE_W), .SETUP_CYC(SETUP_CYC),
    .PULSE_CYC(PULSE_CYC), .HOLD_CYC(HOLD_CYC)
  ) u_seq (
    .clk(clk), .rst(rst), .twos(cfg_twos), .load_req(load_req),
    .load_code(mapped_code), .dac_data(dac_data),
    .dac_cs_n(dac_cs_n), .dac_wr_n(dac_wr_n), .busy(busy)
  );

  // R4: a write to a foreign window is accepted without starting a sequence
  a_r4_foreign_block: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_ready && cfg_addr_mode &&
     bus_addr[ADDR_W-1 -: BLK_W] != cfg_block) |=> bus_ready);

  // R8: an accepted load makes the bus wait on the next cycle
  a_r8_stall_after_load: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_ready && cfg_addr_mode &&
     bus_addr[ADDR_W-1 -: BLK_W] == cfg_block) |=> !bus_ready);

  // R1: strobes idle high while the bus is free
  a_r1_idle_strobes: assert property (@(posedge clk) disable iff (rst)
    bus_ready |-> (dac_cs_n && dac_wr_n));
endmodule

// File: tb/tb_dacbus_loader.sv
module tb_dacbus_loader;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_addr_mode = 1'b0;
  logic        cfg_twos = 1'b0;
  logic [3:0]  cfg_block = 4'h5;
  logic        bus_we = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_ready;
  logic [11:0] dac_data;
  logic        dac_cs_n, dac_wr_n;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  dacbus_loader dut (
    .clk(clk), .rst(rst), .cfg_addr_mode(cfg_addr_mode), .cfg_twos(cfg_twos),
    .cfg_block(cfg_block), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ready(bus_ready), .dac_data(dac_data),
    .dac_cs_n(dac_cs_n), .dac_wr_n(dac_wr_n)
  );

  always #5 clk = ~clk;

  // Pin monitor: measures each strobe pulse
  int          pulses = 0;
  int          cur_len = 0;
  int          last_len = 0;
  logic [11:0] prev_data = '0;
  logic [11:0] pulse_data = '0;
  logic [11:0] last_code = '0;
  bit          in_pulse = 0;
  bit          setup_ok = 1, stable_ok = 1, hold_ok = 1;

  always @(negedge clk) begin
    if (rst) begin
      in_pulse = 0;
    end else begin
      if (!dac_wr_n) begin
        if (!in_pulse) begin
          pulse_data = dac_data;
          setup_ok   = (dac_data == prev_data);
          stable_ok  = 1;
          cur_len    = 0;
        end
        if (dac_data != pulse_data || dac_cs_n) stable_ok = 0;
        cur_len++;
        in_pulse = 1;
      end else if (in_pulse) begin
        in_pulse  = 0;
        pulses++;
        last_len  = cur_len;
        last_code = pulse_data;
        hold_ok   = (dac_data == pulse_data);
      end
    end
    prev_data = dac_data;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d, output int stalls);
    stalls = 0;
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    while (!bus_ready) begin
      stalls++;
      @(negedge clk);
    end
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!bus_ready) @(negedge clk);
    repeat (2) @(negedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #1;
  endtask

  task automatic check_pulse(input string req, input logic [11:0] exp_code, input int exp_pulses);
    check(pulses == exp_pulses, req, pulses, exp_pulses);
    check(last_code == exp_code, req, last_code, exp_code);
    check(dac_data == exp_code, req, dac_data, exp_code);
  endtask

  task automatic t_reset_plain();
    cfg_twos = 0; cfg_addr_mode = 0;
    do_reset();
    check(dac_data == 12'h000, "R1", dac_data, 12'h000);
    check(dac_cs_n && dac_wr_n, "R1", {dac_cs_n, dac_wr_n}, 2'b11);
    check(bus_ready == 1'b1, "R1", bus_ready, 1);
  endtask

  task automatic t_byte_load();
    int s;
    int p0;
    p0 = pulses;
    bus_write(16'h4000, 8'hA5, s);
    repeat (15) @(negedge clk);
    #1;
    check(pulses == p0, "R3", pulses, p0);
    check(dac_data == 12'h000, "R3", dac_data, 12'h000);
    bus_write(16'h4001, 8'hF3, s);
    wait_idle();
    check_pulse("R2", 12'h3A5, p0 + 1);
    check(last_len == 10, "R6", last_len, 10);
    check(setup_ok, "R7 setup", setup_ok, 1);
    check(stable_ok, "R7 stable", stable_ok, 1);
    check(hold_ok, "R7 hold", hold_ok, 1);
  endtask

  task automatic t_shadow_reuse();
    int s;
    bus_write(16'h4001, 8'h07, s);
    wait_idle();
    check_pulse("R10", 12'h7A5, pulses == 0 ? 1 : pulses);
    check(last_code == 12'h7A5, "R10", last_code, 12'h7A5);
  endtask

  task automatic t_other_addr();
    int s;
    int p0;
    p0 = pulses;
    bus_write(16'h4002, 8'h11, s);
    bus_write(16'h1234, 8'h22, s);
    bus_write(16'hC000, 8'h33, s);
    repeat (15) @(negedge clk);
    #1;
    check(pulses == p0, "R9", pulses, p0);
    check(dac_data == 12'h7A5, "R9", dac_data, 12'h7A5);
    bus_write(16'h4001, 8'h01, s);
    wait_idle();
    check_pulse("R9", 12'h1A5, p0 + 1);
  endtask

  task automatic t_addr_mode();
    int s;
    int p0;
    cfg_addr_mode = 1; cfg_block = 4'h5;
    p0 = pulses;
    bus_write(16'h5ABC, 8'h00, s);
    wait_idle();
    check_pulse("R4", 12'hABC, p0 + 1);
    check(last_len == 10, "R6", last_len, 10);
    bus_write(16'h6123, 8'h00, s);
    check(s == 0, "R4", s, 0);
    bus_write(16'h4000, 8'h55, s);
    repeat (15) @(negedge clk);
    #1;
    check(pulses == p0 + 1, "R4", pulses, p0 + 1);
    check(dac_data == 12'hABC, "R4", dac_data, 12'hABC);
  endtask

  task automatic t_stall();
    int s1, s2;
    int p0;
    p0 = pulses;
    bus_write(16'h5111, 8'h00, s1);
    bus_write(16'h5222, 8'h00, s2);
    check(s2 > 5, "R8", s2, 6);
    check(pulses == p0 + 1, "R8", pulses, p0 + 1);
    wait_idle();
    check_pulse("R8", 12'h222, p0 + 2);
    check(stable_ok && setup_ok, "R7", {setup_ok, stable_ok}, 2'b11);
  endtask

  task automatic t_twos();
    int s;
    int p0;
    cfg_twos = 1; cfg_addr_mode = 1; cfg_block = 4'h5;
    do_reset();
    check(dac_data == 12'h800, "R1", dac_data, 12'h800);
    check(dac_cs_n && dac_wr_n, "R1", {dac_cs_n, dac_wr_n}, 2'b11);
    p0 = pulses;
    bus_write(16'h57FF, 8'h00, s);
    wait_idle();
    check_pulse("R5", 12'hFFF, p0 + 1);
    bus_write(16'h5800, 8'h00, s);
    wait_idle();
    check_pulse("R5", 12'h000, p0 + 2);
    bus_write(16'h5000, 8'h00, s);
    wait_idle();
    check_pulse("R5", 12'h800, p0 + 3);
    cfg_addr_mode = 0;
    bus_write(16'h4000, 8'h34, s);
    bus_write(16'h4001, 8'h02, s);
    wait_idle();
    check_pulse("R5", 12'hA34, p0 + 4);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset_plain();
    t_byte_load();
    t_shadow_reuse();
    t_other_addr();
    t_addr_mode();
    t_stall();
    t_twos();
    finish_run();
  end
endmodule